// File: doc/BRIEF.md
# External Interrupt Request Flag Logic

This block keeps the pending-request flag for each of a set of active-low external interrupt pins (two by default). Every channel has a trigger-type bit, set by software, that picks between falling-edge detection and low-level detection. Each pin goes through a two-flop synchronizer. A falling edge is found when the previous synchronized sample is 1 and the current one is 0.

Each channel runs a small four-state machine that holds both the trigger type and the flag:

- `CH_EDGE_IDLE`: edge mode, no request pending.
- `CH_EDGE_PEND`: edge mode, a request is latched.
- `CH_LVL_CLR`: level mode, the pin is high.
- `CH_LVL_SET`: level mode, the pin is low.

The transitions are:

- `EDGE_IDLE → EDGE_PEND` on a detected fall.
- `EDGE_PEND → EDGE_IDLE` on an acknowledge with no fall in the same cycle.
- `EDGE_PEND → EDGE_PEND` on an acknowledge that coincides with a fall.
- `LVL_CLR ↔ LVL_SET` following the synchronized pin level.
- A software write loads any state directly:
  - trigger 1 with flag 1 selects `EDGE_PEND`.
  - trigger 1 with flag 0 selects `EDGE_IDLE`.
  - trigger 0 selects `LVL_SET` or `LVL_CLR` according to the pin, whatever flag value is written.

The interrupt controller gives one acknowledge strobe per channel when it vectors to that channel's handler. Software writes all trigger and flag bits at once through a one-cycle write strobe. The current values can be read back on the flag and trigger outputs. A software write takes priority over any hardware event in the same cycle.

Top module: `ext_irq_flags`

## Requirements
- R1: After reset, every flag and every trigger-type bit reads 0 (level mode, no request), given pins held high.
- R2: With trigger-type 1 (edge mode), a 1-to-0 transition on the pin sets the flag. The flag stays set after the pin returns high, and a steady low does not set it again.
- R3: With trigger-type 0 (level mode), the flag is 1 whenever the synchronized pin is 0 and 0 whenever it is 1.
- R4: In edge mode, an acknowledge strobe clears the flag on the next clock edge.
- R5: In level mode, the acknowledge strobe has no effect: the flag stays 1 while the pin is low.
- R6: In edge mode, if a newly detected fall and an acknowledge fall in the same cycle, the flag remains 1.
- R7: A software write with trigger bit 1 loads the written flag value. A write with trigger bit 0 ignores the written flag value, and the flag reflects the pin.
- R8: Trigger-type bits change only on a write, and they read back the written value one clock after the write.
- R9: Channels are independent. Pin activity, acknowledges and mode on one channel never alter another channel's flag.
- R10: A pin change driven before clock edge k shows on the flag after edge k+2 (three edges of latency), in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NUM_CH | Asynchronous active-low interrupt pins |
| ack | input | NUM_CH | Per-channel acknowledge (vector) strobe |
| wr_en | input | 1 | Software write strobe |
| wr_trig | input | NUM_CH | Trigger-type bits to write (1 = falling edge, 0 = low level) |
| wr_flag | input | NUM_CH | Flag bits to write (used only for edge-mode channels) |
| irq_flag | output | NUM_CH | Request flags |
| irq_trig | output | NUM_CH | Current trigger-type bits |

## Verification
The acknowledge strobe and a freshly detected falling edge can land in the same cycle on one channel. The bench provokes this by driving the pin low and then raising the acknowledge exactly two edges later, so that both are seen at the third edge. It then checks that the flag is still set; a control run with the acknowledge alone must clear it. The other overlap, a software write against pin activity, is judged by the write winning. Sweeps over every 4-step pin pattern in both modes, on both channels at once, compare each flag against values computed arithmetically from the pattern.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        CH_LVL_CLR   = 2'b00,
        CH_LVL_SET   = 2'b01,
        CH_EDGE_IDLE = 2'b10,
        CH_EDGE_PEND = 2'b11
    } ch_state_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_fall_det.sv
module irq_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= level;
    end

    assign fall = prev_q & ~level;
endmodule

// File: rtl/irq_chan_fsm.sv
module irq_chan_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic fall,
    input  logic ack,
    input  logic wr_en,
    input  logic wr_trig,
    input  logic wr_flag,
    output logic flag,
    output logic trig
);
    ch_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_LVL_CLR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_trig) state_d = wr_flag ? CH_EDGE_PEND : CH_EDGE_IDLE;
            else         state_d = pin_s ? CH_LVL_CLR : CH_LVL_SET;
        end else begin
            unique case (state_q)
                CH_EDGE_IDLE: if (fall) state_d = CH_EDGE_PEND;
                CH_EDGE_PEND: if (ack && !fall) state_d = CH_EDGE_IDLE;
                CH_LVL_CLR:   if (!pin_s) state_d = CH_LVL_SET;
                CH_LVL_SET:   if (pin_s) state_d = CH_LVL_CLR;
                default:      state_d = CH_LVL_CLR;
            endcase
        end
    end

    always_comb begin
        flag = 1'b0;
        trig = 1'b0;
        unique case (state_q)
            CH_EDGE_IDLE: begin flag = 1'b0; trig = 1'b1; end
            CH_EDGE_PEND: begin flag = 1'b1; trig = 1'b1; end
            CH_LVL_CLR:   begin flag = 1'b0; trig = 1'b0; end
            CH_LVL_SET:   begin flag = 1'b1; trig = 1'b0; end
            default:      begin flag = 1'b0; trig = 1'b0; end
        endcase
    end

    // R2: a detected fall in edge mode leaves the flag set
    a_r2_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && fall && !wr_en) |=> flag);
    // R4: acknowledge without a new fall clears an edge request
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && flag && ack && !fall && !wr_en) |=> !flag);
    // R6: coincident fall and acknowledge keep the request
    a_r6_no_lost_req: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && flag && ack && fall && !wr_en) |=> flag);
    // R3, R5: level mode flag mirrors the inverted synchronized pin
    a_r5_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !wr_en) |=> (flag == !$past(pin_s)));
    // R8: trigger type moves only on a write
    a_r8_trig_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(trig));
    // R7: edge-mode write loads the flag
    a_r7_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_trig) |=> (flag == $past(wr_flag)));
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags #(
    parameter int NUM_CH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_n,
    input  logic [NUM_CH-1:0] ack,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] wr_trig,
    input  logic [NUM_CH-1:0] wr_flag,
    output logic [NUM_CH-1:0] irq_flag,
    output logic [NUM_CH-1:0] irq_trig
);
    logic [NUM_CH-1:0] pin_s;
    logic [NUM_CH-1:0] fall;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (pin_n[c]),
                .dout  (pin_s[c])
            );

            irq_fall_det u_fall (
                .clk   (clk),
                .rst_n (rst_n),
                .level (pin_s[c]),
                .fall  (fall[c])
            );

            irq_chan_fsm u_fsm (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_s   (pin_s[c]),
                .fall    (fall[c]),
                .ack     (ack[c]),
                .wr_en   (wr_en),
                .wr_trig (wr_trig[c]),
                .wr_flag (wr_flag[c]),
                .flag    (irq_flag[c]),
                .trig    (irq_trig[c])
            );
        end
    endgenerate

    // R9: an acknowledge on one channel never raises any flag
    a_r9_ack_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (ack != '0) && (fall == '0) && (pin_s == '1)) |=> ((irq_flag & ~$past(irq_flag)) == '0));
endmodule

// File: tb/sim_ext_irq_flags.sv
`timescale 1ns/1ps
module sim_ext_irq_flags;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_n = '1;
    logic [N-1:0] ack = '0;
    logic         wr_en = 1'b0;
    logic [N-1:0] wr_trig = '0;
    logic [N-1:0] wr_flag = '0;
    logic [N-1:0] irq_flag;
    logic [N-1:0] irq_trig;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ext_irq_flags #(.NUM_CH(N), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .ack(ack),
        .wr_en(wr_en), .wr_trig(wr_trig), .wr_flag(wr_flag),
        .irq_flag(irq_flag), .irq_trig(irq_trig)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic swr(input logic [N-1:0] t, input logic [N-1:0] f);
        wr_trig = t; wr_flag = f; wr_en = 1'b1;
        cyc(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack(input logic [N-1:0] a);
        ack = a;
        cyc(1);
        ack = '0;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(3);
        chk("R1 flags", irq_flag, 2'b00);
        chk("R1 trig", irq_trig, 2'b00);

        // R3/R10 level mode latency and tracking on channel 0
        pin_n = 2'b10;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 early", irq_flag, 2'b00);
        @(posedge clk); @(negedge clk);
        chk("R10 level latency", irq_flag, 2'b01);
        // R5 ack ignored in level mode
        pulse_ack(2'b01);
        chk("R5 ack ignored", irq_flag, 2'b01);
        pin_n = 2'b11;
        cyc(3);
        chk("R3 level release", irq_flag, 2'b00);

        // R7 flag write ignored in level mode
        swr(2'b00, 2'b11);
        chk("R7 level write ignored", irq_flag, 2'b00);

        // R8 trig write read back
        swr(2'b01, 2'b00);
        chk("R8 trig readback", irq_trig, 2'b01);
        chk("R8 flags after write", irq_flag, 2'b00);

        // R2/R10 edge set on channel 0, latency
        pin_n = 2'b10;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R10 edge early", irq_flag, 2'b00);
        @(posedge clk); @(negedge clk);
        chk("R2 edge set", irq_flag, 2'b01);
        cyc(4);
        chk("R2 held low", irq_flag, 2'b01);
        // R4 ack clears, steady low does not re-set
        pulse_ack(2'b01);
        chk("R4 ack clears", irq_flag, 2'b00);
        cyc(4);
        chk("R2 no reset on steady low", irq_flag, 2'b00);
        pin_n = 2'b11;
        cyc(4);
        chk("R2 rising no set", irq_flag, 2'b00);

        // R6 coincident fall and ack, flag already set
        swr(2'b01, 2'b01);
        chk("R7 edge write set", irq_flag, 2'b01);
        pin_n = 2'b10;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ack = 2'b01;
        cyc(1);
        ack = '0;
        chk("R6 coincident keeps", irq_flag, 2'b01);
        pulse_ack(2'b01);
        chk("R6 control ack clears", irq_flag, 2'b00);
        pin_n = 2'b11;
        cyc(4);
        swr(2'b01, 2'b00);
        chk("R7 edge write clear", irq_flag, 2'b00);

        // R9 independence: channel 1 level low while channel 0 edge idle
        swr(2'b01, 2'b00);
        pin_n = 2'b01;
        cyc(4);
        chk("R9 ch1 only", irq_flag, 2'b10);
        pulse_ack(2'b11);
        chk("R9 ack on both", irq_flag, 2'b10);
        pin_n = 2'b11;
        cyc(4);

        // sweep: every mode pair and 4-step pin pattern
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 16; p++) begin
                logic [N-1:0] prev;
                logic [N-1:0] exp;
                logic [3:0] pat [N];
                pat[0] = 4'(p);
                pat[1] = 4'(p ^ 5);
                pin_n = '1;
                cyc(4);
                swr(2'(m), 2'b00);
                prev = '1;
                exp = '0;
                for (int s = 0; s < 4; s++) begin
                    logic [N-1:0] cur;
                    for (int c = 0; c < N; c++) cur[c] = pat[c][s];
                    pin_n = cur;
                    cyc(4);
                    for (int c = 0; c < N; c++) begin
                        if (m[c]) exp[c] = exp[c] | (prev[c] & ~cur[c]);
                        else      exp[c] = ~cur[c];
                    end
                    prev = cur;
                    chk("R2 R3 R9 sweep", irq_flag, exp);
                end
                pulse_ack(2'b11);
                for (int c = 0; c < N; c++)
                    if (m[c]) exp[c] = 1'b0;
                chk("R4 R5 sweep ack", irq_flag, exp);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule